// File: doc/BRIEF.md
# Timer Timebase Clock-Enable Generator with Lockable Configuration

This block produces two single-cycle clock enables, `tick1` and `tick2`, that advance the two free-running timebase counters of a timer coprocessor. Both enables are created in the system clock domain. No derived clock is ever produced. The first enable comes from a divided system clock. That divider runs at one of two standard rates or at a programmable extended rate, and a power-of-two prescaler follows it. The second enable comes from an external timer pin. The pin is synchronised through two flip-flops before use. It acts either as an edge-counted clock source or as a level gate on an internal divide-by-8 event, and a second power-of-two prescaler follows.

A 16-bit configuration register is written one byte at a time. `wr_hi` selects bits 15:8, and otherwise bits 7:0 are written. A write takes effect on the clock edge where `wr_en` is high. `rd_data` shows the register contents from the following cycle. Three fields are write-once: the second prescaler ratio, the mode bit and the emulation bit. Each has its own lock flag, which sets on the first write to its byte after reset. When the `wr_override` strap is high, locked fields can be rewritten. A stop control bit halts both enables, and a read-only flag reports its state.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: After reset, rd_data reads 0x0800, meaning only the mode bit (bit 11) is set. With the pin idle, tick2 stays low, and tick1 pulses once every 32 clocks.
- R2: While the extended enable (bit 7) is 0, the base-rate bit (bit 6) sets the first counter's base division. A value of 0 gives 32 clocks and 1 gives 4 clocks. tick1 is never high in two adjacent cycles.
- R3: While bit 7 is 1, the base division is 2*(N+1) clocks, where N is bits 10:8, and bit 6 has no effect on the rate.
- R4: The first prescaler field (bits 5:4) with value k passes one of every 2^k base events to tick1.
- R5: While the gate bit (bit 2) is 0, edges of the synchronised pin are the events for the second counter. Bit 3 = 0 selects rising edges and 1 selects falling edges. Field bits 1:0 divide the events: 00 by 1, 01 by 2, 10 by 4, 11 by 8. tick2 is never high in two adjacent cycles.
- R6: While bit 2 is 1, an event occurs every 8 clocks while the synchronised pin is at its active level, and no event occurs otherwise. The active level is high when bit 3 = 0 and low when bit 3 = 1. The bits 1:0 prescaler then divides these events.
- R7: Bits 1:0 take only the first low-byte write after reset. While wr_override is low, later low-byte writes leave them unchanged but still update bits 7:2.
- R8: The mode bit (bit 11, reset value 1) and the emulation bit (bit 12) each take only the first high-byte write after reset. Each has its own lock. While wr_override is low, later high-byte writes leave both unchanged but still update bits 10:8 and 13.
- R9: While wr_override is high, a write updates bits 1:0, 11 and 12 whatever their lock state.
- R10: Bit 13 is the stop control, and bit 14 is a read-only flag that reads the same value. While stopped, neither tick is produced. Bits 14 and 15 ignore writes, and bit 15 always reads 0.
- R11: A write that changes a ratio field restarts that field's divider from zero. After a low-byte write that changes bits 7:6 to 01 with bits 5:4 at 00, tick1 stays low until the cycle that follows the fourth clock edge after the write edge, and it is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External timer pin, asynchronous |
| wr_en | input | 1 | Register byte write strobe |
| wr_hi | input | 1 | 1 selects bits 15:8, 0 selects bits 7:0 |
| wr_data | input | 8 | Byte write data |
| wr_override | input | 1 | Strap that permits rewriting locked fields |
| tick1 | output | 1 | Single-cycle advance enable for the first counter |
| tick2 | output | 1 | Single-cycle advance enable for the second counter |
| rd_data | output | 16 | Configuration register readback |

## Verification
The bench rewrites the locked ratio, mode and emulation fields without the strap. A design whose lock was shared or missing would change the readback, and one that locked the whole byte would also freeze the neighbouring free fields. It sets the base-rate bit while the extended divider is active, which exposes a design that does not let the extended selection win. It drives single pin transitions in the wrong direction for the selected edge, and holds the gate pin at the inactive level. A design with a swapped polarity would produce ticks there. It times the first tick after a ratio change cycle by cycle, which catches a divider that keeps its old count, and it checks that both enables stay silent while stopped.

// File: rtl/tmr_psc_pkg.sv
package tmr_psc_pkg;

    localparam int RATIO_SEL_W = 2;
    localparam int EXT_RATIO_W = 3;

    typedef struct packed {
        logic [RATIO_SEL_W-1:0] t2_div;
        logic                   gate_mode;
        logic                   edge_fall;
        logic [RATIO_SEL_W-1:0] t1_div;
        logic                   base_fast;
        logic                   ext_en;
        logic [EXT_RATIO_W-1:0] ext_ratio;
        logic                   mode;
        logic                   emu;
        logic                   stop;
    } cfg_t;

    typedef struct packed {
        logic t2_div;
        logic mode;
        logic emu;
    } lock_t;

    typedef struct packed {
        cfg_t  cfg;
        lock_t lk;
    } cfg_state_t;

    localparam cfg_t CFG_RESET = '{
        t2_div:    '0,
        gate_mode: 1'b0,
        edge_fall: 1'b0,
        t1_div:    '0,
        base_fast: 1'b0,
        ext_en:    1'b0,
        ext_ratio: '0,
        mode:      1'b1,
        emu:       1'b0,
        stop:      1'b0
    };

endpackage

// File: rtl/tp_cfg_regs.sv
module tp_cfg_regs
    import tmr_psc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hi,
    input  logic [7:0]             wr_data,
    input  logic                   wr_override,
    output logic [RATIO_SEL_W-1:0] t2_div,
    output logic                   gate_mode,
    output logic                   edge_fall,
    output logic [RATIO_SEL_W-1:0] t1_div,
    output logic                   base_fast,
    output logic                   ext_en,
    output logic [EXT_RATIO_W-1:0] ext_ratio,
    output logic                   stop,
    output logic                   rst_base,
    output logic                   rst_t1psc,
    output logic                   rst_t2psc,
    output logic                   rst_gate,
    output logic [15:0]            rd_data
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_hi) begin
            if (!st_q.lk.t2_div || wr_override) begin
                st_d.cfg.t2_div = wr_data[1:0];
            end
            st_d.lk.t2_div      = 1'b1;
            st_d.cfg.gate_mode  = wr_data[2];
            st_d.cfg.edge_fall  = wr_data[3];
            st_d.cfg.t1_div     = wr_data[5:4];
            st_d.cfg.base_fast  = wr_data[6];
            st_d.cfg.ext_en     = wr_data[7];
        end
        if (wr_en && wr_hi) begin
            st_d.cfg.ext_ratio = wr_data[2:0];
            if (!st_q.lk.mode || wr_override) begin
                st_d.cfg.mode = wr_data[3];
            end
            if (!st_q.lk.emu || wr_override) begin
                st_d.cfg.emu = wr_data[4];
            end
            st_d.cfg.stop = wr_data[5];
            st_d.lk.mode  = 1'b1;
            st_d.lk.emu   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, lk: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_base  = (st_d.cfg.base_fast != st_q.cfg.base_fast)
                     | (st_d.cfg.ext_en    != st_q.cfg.ext_en)
                     | (st_d.cfg.ext_ratio != st_q.cfg.ext_ratio);
    assign rst_t1psc = (st_d.cfg.t1_div    != st_q.cfg.t1_div);
    assign rst_t2psc = (st_d.cfg.t2_div    != st_q.cfg.t2_div);
    assign rst_gate  = (st_d.cfg.gate_mode != st_q.cfg.gate_mode);

    assign t2_div    = st_q.cfg.t2_div;
    assign gate_mode = st_q.cfg.gate_mode;
    assign edge_fall = st_q.cfg.edge_fall;
    assign t1_div    = st_q.cfg.t1_div;
    assign base_fast = st_q.cfg.base_fast;
    assign ext_en    = st_q.cfg.ext_en;
    assign ext_ratio = st_q.cfg.ext_ratio;
    assign stop      = st_q.cfg.stop;

    assign rd_data = {1'b0, st_q.cfg.stop, st_q.cfg.stop, st_q.cfg.emu,
                      st_q.cfg.mode, st_q.cfg.ext_ratio, st_q.cfg.ext_en,
                      st_q.cfg.base_fast, st_q.cfg.t1_div, st_q.cfg.edge_fall,
                      st_q.cfg.gate_mode, st_q.cfg.t2_div};

endmodule

// File: rtl/tp_pin_cond.sv
module tp_pin_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign level = sh_q[SYNC_STAGES-1];
    assign rise  =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall  = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

endmodule

// File: rtl/tp_rate_div.sv
module tp_rate_div #(
    parameter int LIM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             hold,
    input  logic [LIM_W-1:0] limit,
    output logic             pulse
);

    logic [LIM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        pulse = !restart && !hold && (cnt_q >= limit);
        if (restart) begin
            cnt_d = '0;
        end else if (hold) begin
            cnt_d = cnt_q;
        end else if (pulse) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tp_pow2_psc.sv
module tp_pow2_psc #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    input  logic             ev,
    output logic             tick
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } psc_t;

    psc_t             st_d, st_q;
    logic [CNT_W:0]   span;
    logic             last;

    always_comb begin
        span = (CNT_W+1)'(1) << sel;
        last = (st_q.cnt == CNT_W'(span - 1'b1));
        st_d = '{cnt: st_q.cnt, tick: 1'b0};
        if (restart) begin
            st_d.cnt = '0;
        end else if (!hold && ev) begin
            if (last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler
    import tmr_psc_pkg::*;
#(
    parameter int SLOW_DIV    = 32,
    parameter int FAST_DIV    = 4,
    parameter int GATE_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_pin,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [7:0]  wr_data,
    input  logic        wr_override,
    output logic        tick1,
    output logic        tick2,
    output logic [15:0] rd_data
);

    localparam int BASE_W = $clog2(SLOW_DIV);
    localparam int GATE_W = $clog2(GATE_DIV);

    logic [RATIO_SEL_W-1:0] t2_div, t1_div;
    logic                   gate_mode, edge_fall, base_fast, ext_en, stop;
    logic [EXT_RATIO_W-1:0] ext_ratio;
    logic                   rst_base, rst_t1psc, rst_t2psc, rst_gate;
    logic                   pin_lvl, pin_rise, pin_fall;
    logic                   base_ev, gate_ev, t2_ev;
    logic [BASE_W-1:0]      base_limit;

    tp_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .wr_override(wr_override),
        .t2_div     (t2_div),
        .gate_mode  (gate_mode),
        .edge_fall  (edge_fall),
        .t1_div     (t1_div),
        .base_fast  (base_fast),
        .ext_en     (ext_en),
        .ext_ratio  (ext_ratio),
        .stop       (stop),
        .rst_base   (rst_base),
        .rst_t1psc  (rst_t1psc),
        .rst_t2psc  (rst_t2psc),
        .rst_gate   (rst_gate),
        .rd_data    (rd_data)
    );

    tp_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .level(pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    always_comb begin
        if (ext_en) begin
            base_limit = BASE_W'({ext_ratio, 1'b1});
        end else if (base_fast) begin
            base_limit = BASE_W'(FAST_DIV - 1);
        end else begin
            base_limit = BASE_W'(SLOW_DIV - 1);
        end
    end

    tp_rate_div #(.LIM_W(BASE_W)) u_base_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(rst_base),
        .hold   (stop),
        .limit  (base_limit),
        .pulse  (base_ev)
    );

    tp_rate_div #(.LIM_W(GATE_W)) u_gate_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(rst_gate),
        .hold   (stop),
        .limit  (GATE_W'(GATE_DIV - 1)),
        .pulse  (gate_ev)
    );

    always_comb begin
        if (gate_mode) begin
            t2_ev = gate_ev & (pin_lvl ^ edge_fall);
        end else begin
            t2_ev = edge_fall ? pin_fall : pin_rise;
        end
    end

    tp_pow2_psc #(.SEL_W(RATIO_SEL_W)) u_t1_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(rst_t1psc),
        .hold   (stop),
        .sel    (t1_div),
        .ev     (base_ev),
        .tick   (tick1)
    );

    tp_pow2_psc #(.SEL_W(RATIO_SEL_W)) u_t2_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(rst_t2psc),
        .hold   (stop),
        .sel    (t2_div),
        .ev     (t2_ev),
        .tick   (tick2)
    );

endmodule

module tp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_hi,
    input logic [1:0] wr_top,
    input logic       wr_override,
    input logic       tick1,
    input logic       tick2,
    input logic [1:0] t2_fld,
    input logic [1:0] once_fld,
    input logic [1:0] base_fld,
    input logic       stop_fl
);

    logic seen_lo_q, seen_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else begin
            if (wr_en && !wr_hi) seen_lo_q <= 1'b1;
            if (wr_en &&  wr_hi) seen_hi_q <= 1'b1;
        end
    end

    p_tick1_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |=> !tick1);

    p_tick2_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick2 |=> !tick2);

    p_t2div_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_lo_q && !(wr_en && !wr_hi && wr_override)) |=> $stable(t2_fld));

    p_mode_emu_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_hi_q && !(wr_en && wr_hi && wr_override)) |=> $stable(once_fld));

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_fl && $past(stop_fl)) |-> (!tick1 && !tick2));

    p_restart_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && !stop_fl && wr_top == 2'b01 && base_fld == 2'b00)
        |=> !tick1 ##1 !tick1);

endmodule

bind tmr_clk_prescaler tp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_hi      (wr_hi),
    .wr_top     (wr_data[7:6]),
    .wr_override(wr_override),
    .tick1      (tick1),
    .tick2      (tick2),
    .t2_fld     (rd_data[1:0]),
    .once_fld   (rd_data[12:11]),
    .base_fld   (rd_data[7:6]),
    .stop_fl    (rd_data[14])
);

// File: tb/tb_tmr_clk_prescaler.sv
module tb_tmr_clk_prescaler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_override = 1'b0;
    logic        tick1, tick2;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    tmr_clk_prescaler dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .wr_override(wr_override),
        .tick1      (tick1),
        .tick2      (tick2),
        .rd_data    (rd_data)
    );

    typedef struct {
        string tag;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   act_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   t1_acc = 0;
    int   t2_acc = 0;
    bit   done = 1'b0;

    task automatic expect_val(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int val);
        act_q.push_back(val);
    endtask

    // Monitor: pops expected and observed items in order and compares them.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                exp_t e;
                int   a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_checks++;
                if (a != e.val) begin
                    n_errors++;
                    $display("FAIL %s: actual=0x%0h expected=0x%0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            t1_acc += int'(tick1);
            t2_acc += int'(tick2);
        end
    endtask

    task automatic zero_acc();
        t1_acc = 0;
        t2_acc = 0;
    endtask

    task automatic wr(input bit hi, input logic [7:0] d, input bit ovr);
        step(1);
        wr_en       = 1'b1;
        wr_hi       = hi;
        wr_data     = d;
        wr_override = ovr;
        step(1);
        wr_en       = 1'b0;
        wr_override = 1'b0;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1;
            step(3);
            ext_pin = 1'b0;
            step(3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int first_idx;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1: reset state
        expect_val("R1 reset readback", 16'h0800); observe(int'(rd_data));
        zero_acc(); step(1024);
        expect_val("R1 tick1 every 32 after reset", 32); observe(t1_acc);
        expect_val("R1 tick2 idle pin", 0); observe(t2_acc);

        // R2: fast base, t2 ratio field 10 (divide by 4), rising edges
        wr(1'b0, 8'h42, 1'b0);
        expect_val("R2 readback after first low write", 16'h0842); observe(int'(rd_data));
        step(300); zero_acc(); step(256);
        expect_val("R2 tick1 every 4", 64); observe(t1_acc);

        // R5: 16 rising edges through divide by 4
        zero_acc(); pin_pulses(16); step(10);
        expect_val("R5 rising edges div4", 4); observe(t2_acc);

        // R7: locked ratio field ignores a plain write, neighbours still update
        wr(1'b0, 8'h48, 1'b0);
        expect_val("R7 locked t2 field kept", 16'h084A); observe(int'(rd_data));

        // R9: override rewrites the locked field
        wr(1'b0, 8'h40, 1'b1);
        expect_val("R9 override low byte", 16'h0840); observe(int'(rd_data));

        // R5: falling edge selection, divide by 1
        wr(1'b0, 8'h48, 1'b0);
        zero_acc(); ext_pin = 1'b1; step(10);
        expect_val("R5 falling mode ignores rising edge", 0); observe(t2_acc);
        zero_acc(); ext_pin = 1'b0; step(10);
        expect_val("R5 falling edge counted", 1); observe(t2_acc);

        // R6: gate mode, active high
        wr(1'b0, 8'h44, 1'b0);
        step(20); zero_acc(); step(160);
        expect_val("R6 gate inactive level", 0); observe(t2_acc);
        ext_pin = 1'b1; step(10); zero_acc(); step(160);
        expect_val("R6 gate active every 8", 20); observe(t2_acc);
        wr(1'b0, 8'h45, 1'b1);
        expect_val("R9 override to div2", 16'h0845); observe(int'(rd_data));
        step(40); zero_acc(); step(320);
        expect_val("R6 gate with divide by 2", 20); observe(t2_acc);
        wr(1'b0, 8'h4D, 1'b0);
        step(20); zero_acc(); step(160);
        expect_val("R6 active-low gate with pin high", 0); observe(t2_acc);

        // R8: mode and emulation write-once
        wr(1'b1, 8'h10, 1'b0);
        expect_val("R8 first high write", 16'h104D); observe(int'(rd_data));
        wr(1'b1, 8'h08, 1'b0);
        expect_val("R8 locked mode/emu kept", 16'h104D); observe(int'(rd_data));
        wr(1'b1, 8'h08, 1'b1);
        expect_val("R9 override high byte", 16'h084D); observe(int'(rd_data));

        // R3: extended divider 2*(4+1)=10, prescaler k=1 -> 20
        wr(1'b0, 8'h91, 1'b0);
        wr(1'b1, 8'h0C, 1'b0);
        expect_val("R3 readback", 16'h0C91); observe(int'(rd_data));
        step(300); zero_acc(); step(200);
        expect_val("R3 extended rate", 10); observe(t1_acc);
        wr(1'b0, 8'hD1, 1'b0);
        step(300); zero_acc(); step(200);
        expect_val("R3 base-rate bit ignored", 10); observe(t1_acc);

        // R11: restart, first tick after 4th edge following the write edge
        wr(1'b0, 8'h41, 1'b0);
        first_idx = 0;
        for (int i = 1; i <= 12; i++) begin
            if (i > 1) step(1);
            if (tick1 && first_idx == 0) first_idx = i;
        end
        expect_val("R11 first tick1 position", 5); observe(first_idx);

        // R4: k=3 with fast base -> period 32
        wr(1'b0, 8'h71, 1'b0);
        step(300); zero_acc(); step(256);
        expect_val("R4 prescale by 8", 8); observe(t1_acc);

        // R10: stop
        ext_pin = 1'b0; step(10);
        wr(1'b1, 8'h2C, 1'b0);
        expect_val("R10 stop flag readback", 16'h6C71); observe(int'(rd_data));
        step(3); zero_acc(); pin_pulses(8); step(252);
        expect_val("R10 tick1 silent when stopped", 0); observe(t1_acc);
        expect_val("R10 tick2 silent when stopped", 0); observe(t2_acc);
        wr(1'b1, 8'hCC, 1'b0);
        expect_val("R10 flag and reserved bits ignore writes", 16'h0C71); observe(int'(rd_data));
        step(300); zero_acc(); step(256);
        expect_val("R10 ticks resume", 8); observe(t1_acc);

        step(3);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            n_errors++;
            n_checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule